// File: doc/BRIEF.md
# Dual-Lane Wide-to-Narrow Word Serializer

This block turns one 128-bit parallel word into eight consecutive 16-bit samples for a converter that runs eight times faster than the word source. The 128-bit word is split into two lanes. The even lane holds samples 0, 2, 4 and 6, and the odd lane holds samples 1, 3, 5 and 7. Each lane is a four-chunk shift register that only moves on alternate fast-clock edges, so no lane has to sustain the full sample rate. A final stage works like a double-data-rate output register. It takes the even lane on one phase of the divide-by-two enable and the odd lane on the other, which rebuilds the sample stream in order.

A slot counter splits the fast clock into eight-slot frames. The input word is captured only on the last slot of a frame. A frame clock at one eighth of the sample rate goes back to the upstream producer so that it can present the next word in time. Pulling the sync input low restarts the frame and empties the pipeline.

Top module: `dual_lane_serializer`

## Requirements
- R1: An active-low asynchronous reset (`rstN`) drives `dataOut`, `evenLane`, `oddLane` and `frameClk` to zero while it is held.
- R2: A clock edge that samples `syncIn` low clears the lanes and the output to zero, drives `frameClk` low and sends the slot counter back to slot 0. The first edge that later samples `syncIn` high is edge 1 of a new frame sequence.
- R3: Counting edges that sample `syncIn` high from 1, the edges numbered 8, 16, 24 and so on capture `dataIn`. A value on `dataIn` at any other edge has no effect on any output.
- R4: Word j is the (j+1)-th captured word. Slice k of a word is bits [127-16k : 112-16k], so slice 0 is the top 16 bits. After edge 9+8j+k, `dataOut` shows slice k of word j, for k from 0 to 7.
- R5: `dataOut` stays zero from a restart until the first captured word begins to appear at edge 9.
- R6: After edge e of a running sequence, `frameClk` is high when (e-1) mod 8 is 5, 6 or 7 and low otherwise. As a result it is high while `dataOut` shows slices 5 to 7.
- R7: Let m = (e-8) mod 8 after a capture. `evenLane` shows slice 0 at m=0, slice 2 at m=1..2, slice 4 at m=3..4, slice 6 at m=5..6 and zero at m=7. It is zero before the first capture.
- R8: Using the same m, `oddLane` shows slice 1 at m=0..1, slice 3 at m=2..3, slice 5 at m=4..5 and slice 7 at m=6..7. It is zero before the first capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Low holds the frame at slot 0 and empties the pipeline |
| dataIn | input | 128 | Parallel word, sampled on the last slot of a frame |
| evenLane | output | 16 | Top chunk of the even-sample lane |
| oddLane | output | 16 | Top chunk of the odd-sample lane |
| dataOut | output | 16 | Recombined sample stream |
| frameClk | output | 1 | One-eighth-rate frame clock to the word source |

## Verification
A slot counter that is off by one shows up within one frame. `frameClk` would rise on the wrong edge, and every eighth output sample would come from a different word than expected. A lane that shifts on the wrong phase repeats or skips a sample at the very next edge where that lane feeds `dataOut`, so the fault is seen within two cycles. A wrong slice mapping at load time corrupts the first sample of the very next frame. The bench rebuilds every sample from its own word table and compares each cycle, so any of these faults is seen within one frame.

// File: rtl/dlser_pkg.sv
package dlser_pkg;
  // Strobes sent from the frame control to the datapath
  typedef struct packed {
    logic clear;      // sync low: empty lanes and output
    logic load;       // last slot: capture the wide word
    logic evenShift;  // even-phase lane enable
    logic oddShift;   // odd-phase lane enable
    logic pickOdd;    // output stage takes the odd lane this edge
  } serCtrl_t;
endpackage

// File: rtl/dlser_ctrl.sv
module dlser_ctrl
  import dlser_pkg::*;
#(
  parameter int WORDS          = 8,
  parameter int FRAME_HI_START = 5
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     syncIn,
  output serCtrl_t ctl,
  output logic     frameClk
);
  localparam int SLOT_W = $clog2(WORDS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WORDS - 1);
  localparam logic [SLOT_W-1:0] HI_SLOT   = SLOT_W'(FRAME_HI_START);

  logic [SLOT_W-1:0] slotQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotQ    <= '0;
      frameClk <= 1'b0;
    end else if (!syncIn) begin
      slotQ    <= '0;
      frameClk <= 1'b0;
    end else begin
      slotQ    <= (slotQ == LAST_SLOT) ? '0 : slotQ + 1'b1;
      frameClk <= (slotQ >= HI_SLOT);
    end
  end

  // Divide-by-two phase from the slot LSB selects which lane moves
  always_comb begin
    ctl.clear     = !syncIn;
    ctl.load      = syncIn && (slotQ == LAST_SLOT);
    ctl.evenShift = syncIn && !slotQ[0];
    ctl.oddShift  = syncIn && slotQ[0];
    ctl.pickOdd   = slotQ[0];
  end
endmodule

// File: rtl/dlser_lane.sv
module dlser_lane #(
  parameter int WORD_W     = 16,
  parameter int LANE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         clear,
  input  logic                         load,
  input  logic                         shift,
  input  logic [WORD_W*LANE_WORDS-1:0] loadVal,
  output logic [WORD_W-1:0]            laneTop
);
  localparam int LANE_W = WORD_W * LANE_WORDS;

  logic [LANE_W-1:0] laneQ;

  // Chunk shift toward the top: the output never needs a wide select
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      laneQ <= '0;
    else if (clear) laneQ <= '0;
    else if (load)  laneQ <= loadVal;
    else if (shift) laneQ <= {laneQ[LANE_W-WORD_W-1:0], {WORD_W{1'b0}}};
  end

  assign laneTop = laneQ[LANE_W-1 -: WORD_W];
endmodule

// File: rtl/dlser_ddr_out.sv
module dlser_ddr_out #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              pickOdd,
  input  logic [WORD_W-1:0] evenTop,
  input  logic [WORD_W-1:0] oddTop,
  output logic [WORD_W-1:0] dataOut
);
  // Behavioural stand-in for a two-phase output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      dataOut <= '0;
    else if (clear) dataOut <= '0;
    else            dataOut <= pickOdd ? oddTop : evenTop;
  end
endmodule

// File: rtl/dlser_datapath.sv
module dlser_datapath
  import dlser_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WORDS  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  serCtrl_t                ctl,
  input  logic [WORD_W*WORDS-1:0] dataIn,
  output logic [WORD_W-1:0]       evenLane,
  output logic [WORD_W-1:0]       oddLane,
  output logic [WORD_W-1:0]       dataOut
);
  localparam int IN_W       = WORD_W * WORDS;
  localparam int LANE_WORDS = WORDS / 2;
  localparam int LANE_W     = WORD_W * LANE_WORDS;

  logic [LANE_W-1:0] laneLoad [2];
  logic [WORD_W-1:0] laneTop  [2];

  for (genvar p = 0; p < 2; p++) begin : g_lane
    // Lane p gathers samples p, p+2, p+4 ... with the earliest at the top
    for (genvar i = 0; i < LANE_WORDS; i++) begin : g_slice
      assign laneLoad[p][LANE_W-1-i*WORD_W -: WORD_W] =
        dataIn[IN_W-1-(2*i+p)*WORD_W -: WORD_W];
    end
    if (p == 0) begin : g_even
      dlser_lane #(.WORD_W(WORD_W), .LANE_WORDS(LANE_WORDS)) lane_i (
        .clk(clk), .rstN(rstN), .clear(ctl.clear), .load(ctl.load),
        .shift(ctl.evenShift), .loadVal(laneLoad[p]), .laneTop(laneTop[p]));
    end else begin : g_odd
      dlser_lane #(.WORD_W(WORD_W), .LANE_WORDS(LANE_WORDS)) lane_i (
        .clk(clk), .rstN(rstN), .clear(ctl.clear), .load(ctl.load),
        .shift(ctl.oddShift), .loadVal(laneLoad[p]), .laneTop(laneTop[p]));
    end
  end

  assign evenLane = laneTop[0];
  assign oddLane  = laneTop[1];

  dlser_ddr_out #(.WORD_W(WORD_W)) out_i (
    .clk(clk), .rstN(rstN), .clear(ctl.clear), .pickOdd(ctl.pickOdd),
    .evenTop(laneTop[0]), .oddTop(laneTop[1]), .dataOut(dataOut));
endmodule

// File: rtl/dual_lane_serializer.sv
module dual_lane_serializer
  import dlser_pkg::*;
#(
  parameter int WORD_W         = 16,
  parameter int WORDS          = 8,
  parameter int FRAME_HI_START = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    syncIn,
  input  logic [WORD_W*WORDS-1:0] dataIn,
  output logic [WORD_W-1:0]       evenLane,
  output logic [WORD_W-1:0]       oddLane,
  output logic [WORD_W-1:0]       dataOut,
  output logic                    frameClk
);
  serCtrl_t ctlBus;

  dlser_ctrl #(.WORDS(WORDS), .FRAME_HI_START(FRAME_HI_START)) ctrl_i (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .ctl(ctlBus), .frameClk(frameClk));

  dlser_datapath #(.WORD_W(WORD_W), .WORDS(WORDS)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .dataIn(dataIn),
    .evenLane(evenLane), .oddLane(oddLane), .dataOut(dataOut));
endmodule

// File: rtl/dlser_checker.sv
module dlser_checker
  import dlser_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WORDS  = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    syncIn,
  input serCtrl_t                ctl,
  input logic [WORD_W*WORDS-1:0] dataIn,
  input logic [WORD_W-1:0]       evenLane,
  input logic [WORD_W-1:0]       oddLane,
  input logic [WORD_W-1:0]       dataOut,
  input logic                    frameClk
);
  localparam int IN_W = WORD_W * WORDS;

  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !syncIn |=> (dataOut == '0 && evenLane == '0 && oddLane == '0 && !frameClk)); // R2
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (evenLane == $past(dataIn[IN_W-1 -: WORD_W]) &&
                  oddLane  == $past(dataIn[IN_W-WORD_W-1 -: WORD_W]))); // R3
  AST_OUT_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn && !ctl.pickOdd) |=> dataOut == $past(evenLane)); // R4
  AST_OUT_ODD: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn && ctl.pickOdd) |=> dataOut == $past(oddLane)); // R4
  AST_FRAME_RISE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> frameClk); // R6
  AST_FRAME_FALL: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load ##1 syncIn |=> !frameClk); // R6
  AST_EVEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn && !ctl.evenShift && !ctl.load) |=> $stable(evenLane)); // R7
  AST_ODD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn && !ctl.oddShift && !ctl.load) |=> $stable(oddLane)); // R8
endmodule

bind dual_lane_serializer dlser_checker #(.WORD_W(WORD_W), .WORDS(WORDS)) chk_i (
  .clk(clk), .rstN(rstN), .syncIn(syncIn), .ctl(ctlBus), .dataIn(dataIn),
  .evenLane(evenLane), .oddLane(oddLane), .dataOut(dataOut), .frameClk(frameClk));

// File: tb/dual_lane_serializer_tb_top.sv
`timescale 1ns/1ps
module dual_lane_serializer_tb_top;
  localparam int NV = 6;
  localparam logic [127:0] VEC [NV] = '{
    128'h0001_0002_0003_0004_0005_0006_0007_0008,
    128'hA5A5_5A5A_FFFF_0000_1234_5678_9ABC_DEF0,
    128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
    128'h8000_4000_2000_1000_0800_0400_0200_0100,
    128'hC0DE_BEEF_CAFE_F00D_DEAD_0BAD_FACE_B00C,
    128'h1111_2222_3333_4444_5555_6666_7777_8888};

  logic clk = 1'b0;
  logic rstN, syncDrv;
  logic [127:0] dataIn;
  logic [15:0] evenLane, oddLane, dataOut;
  logic frameClk;
  int e, rc, checks, failures;
  string ctxTag;
  bit finished;

  always #2.5 clk = ~clk;

  dual_lane_serializer dut_i (
    .clk(clk), .rstN(rstN), .syncIn(syncDrv), .dataIn(dataIn),
    .evenLane(evenLane), .oddLane(oddLane), .dataOut(dataOut), .frameClk(frameClk));

  function automatic logic [15:0] slice(input int w, input int k);
    logic [127:0] v;
    v = VEC[w % NV];
    return v[127-16*k -: 16];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s e=%0d act=%h exp=%h", req, e, act, exp);
    end
  endtask

  task automatic checkAll();
    logic [15:0] expOut, expEven, expOdd;
    logic expFrame;
    int m, j;
    expOut = '0; expEven = '0; expOdd = '0; expFrame = 1'b0;
    if (e > 0) expFrame = (((e - 1) % 8) >= 5);
    if (e >= 9) expOut = slice((e - 9) / 8 + rc, (e - 9) % 8);
    if (e >= 8) begin
      m = (e - 8) % 8; j = (e - 8) / 8;
      expEven = (m == 7) ? 16'h0 : slice(j + rc, 2 * ((m + 1) / 2));
      expOdd  = slice(j + rc, 2 * (m / 2) + 1);
    end
    if (e == 0) begin
      chk({ctxTag, " dataOut"}, dataOut, expOut);
      chk({ctxTag, " evenLane"}, evenLane, expEven);
      chk({ctxTag, " oddLane"}, oddLane, expOdd);
      chk({ctxTag, " frameClk"}, {15'd0, frameClk}, {15'd0, expFrame});
    end else begin
      chk((e < 9) ? "R5 dataOut zero before first word" : "R4 dataOut order", dataOut, expOut);
      chk((e >= 8 && (e % 8) == 0) ? "R3 evenLane capture" : "R7 evenLane", evenLane, expEven);
      chk((e >= 8 && (e % 8) == 0) ? "R3 oddLane capture" : "R8 oddLane", oddLane, expOdd);
      chk("R6 frameClk", {15'd0, frameClk}, {15'd0, expFrame});
    end
  endtask

  // Junk on every non-capture slot proves only the capture edge matters (R3)
  task automatic driveNext();
    if (syncDrv && rstN && (e % 8) == 7) dataIn = VEC[(e / 8 + rc) % NV];
    else dataIn = {$urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic cycle(input int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      if (!syncDrv || !rstN) e = 0; else e++;
      @(negedge clk);
      checkAll();
      driveNext();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; e = 0; rc = 0; finished = 0;
    rstN = 1'b0; syncDrv = 1'b0; dataIn = '0; ctxTag = "R1 reset";
    repeat (3) @(negedge clk);
    checkAll();                      // R1 reset state
    rstN = 1'b1; ctxTag = "R2 sync low";
    cycle(4);                        // R2 held at slot 0
    syncDrv = 1'b1;
    cycle(8 * NV + 12);              // walk the vector table, R3..R8
    syncDrv = 1'b0; rc++;
    cycle(3);                        // R2 mid-frame restart
    syncDrv = 1'b1;
    cycle(37);
    rstN = 1'b0; e = 0; rc++; ctxTag = "R1 reset";
    #1 checkAll();                   // R1 asynchronous clear
    cycle(2);
    rstN = 1'b1;
    cycle(30);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule